// File: doc/BRIEF.md
# Pipelined Byte-to-Line One-Hot Decoder

The block turns an 8-bit code into a 256-line one-hot vector. It is built as a pipeline with three register stages and the same register count on every path. Stage one registers the incoming byte and its valid flag. Stage two splits the registered byte into an upper and a lower nibble. Each nibble drives its own 4-to-16 predecoder, and the predecoder results are registered. Stage three forms each output line as the registered two-input AND of one upper-nibble line and one lower-nibble line.

Only one small logic level sits between any two flip-flops. The pipeline takes a new code on every clock, and a result appears three clocks after its code. The line order is reversed: code 0 raises the most significant line, and the all-ones code raises line 0. A valid flag travels through the same three stages as the data. The output vector stays all zeros whenever that flag is low.

Top module: `pipe_onehot_decoder`

## Requirements
- R1: While the synchronous active-high reset is applied, and for the two clocks after it is released, `hot_lines` is all zeros and `hot_valid` is low.
- R2: Whenever `hot_valid` is high, exactly one bit of `hot_lines` is set.
- R3: For an accepted code value v, the bit that is set is bit number 255 minus v. Code 0 sets bit 255 and code 255 sets bit 0.
- R4: `hot_valid` equals the value that `code_valid` had three rising edges earlier. A code presented before rising edge k appears at the outputs after rising edge k+2.
- R5: Codes given on consecutive clocks with no gaps each produce their own correct result on consecutive clocks, with no mixing between neighbours.
- R6: Whenever `hot_valid` is low, `hot_lines` is all zeros. A value on `code_in` that is presented with `code_valid` low has no effect on the outputs.
- R7: A reset applied while codes are in flight discards them all. The outputs stay all zeros until a code accepted after the reset has passed through the three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Qualifies `code_in` in this cycle |
| code_in | input | 8 | Code to decode |
| hot_valid | output | 1 | Qualifies `hot_lines` |
| hot_lines | output | 256 | One-hot result, bit 255 minus code set |

## Verification
The hardest situation to reach is a reset that arrives while all three stages hold different valid codes. That case tests whether any stage keeps stale content that would later leak out as a false line. The stimulus fills the pipeline with back-to-back valid codes, then asserts reset for one clock. While the pipeline refills, it feeds invalid cycles carrying nonzero codes. A further stretch alternates valid and invalid cycles, with garbage codes in the bubbles, so the zero-when-idle rule is exercised between live results and not only at rest.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int CODE_W  = 8;
    localparam int HALF_W  = CODE_W / 2;
    localparam int PRE_N   = 2 ** HALF_W;
    localparam int LINES_N = 2 ** CODE_W;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } code_stage_t;

    typedef struct packed {
        logic             valid;
        logic [PRE_N-1:0] upper;
        logic [PRE_N-1:0] lower;
    } pre_stage_t;

    function automatic logic [LINES_N-1:0] expect_lines(input logic [CODE_W-1:0] v);
        logic [LINES_N-1:0] r;
        r = '0;
        r[LINES_N - 1 - int'(v)] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dec_in_stage.sv
module dec_in_stage
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output code_stage_t       stage_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_o <= '0;
        end else begin
            stage_o.valid <= valid_i;
            stage_o.code  <= code_i;
        end
    end

endmodule

// File: rtl/dec_predec_stage.sv
module dec_predec_stage
    import dec_pkg::*;
#(
    parameter int W = HALF_W,
    parameter int N = 2 ** W
) (
    input  logic          clk,
    input  logic          rst,
    input  code_stage_t   stage_i,
    output pre_stage_t    stage_o
);

    localparam int GROUPS = 2;

    logic [GROUPS-1:0][W-1:0] nib;
    logic [GROUPS-1:0][N-1:0] lines_d;

    assign nib[0] = stage_i.code[W-1:0];
    assign nib[1] = stage_i.code[2*W-1:W];

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        for (genvar k = 0; k < N; k++) begin : g_line
            assign lines_d[g][k] = stage_i.valid && (nib[g] == W'(N - 1 - k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_o <= '0;
        end else begin
            stage_o.valid <= stage_i.valid;
            stage_o.lower <= lines_d[0];
            stage_o.upper <= lines_d[1];
        end
    end

endmodule

// File: rtl/dec_and_array.sv
module dec_and_array
    import dec_pkg::*;
#(
    parameter int N   = PRE_N,
    parameter int OUT = N * N
) (
    input  logic           clk,
    input  logic           rst,
    input  pre_stage_t     stage_i,
    output logic           valid_o,
    output logic [OUT-1:0] lines_o
);

    logic [OUT-1:0] grid_d;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            assign grid_d[r*N + c] = stage_i.upper[r] & stage_i.lower[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            lines_o <= '0;
        end else begin
            valid_o <= stage_i.valid;
            lines_o <= grid_d;
        end
    end

endmodule

// File: rtl/pipe_onehot_decoder.sv
module pipe_onehot_decoder
    import dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               code_valid,
    input  logic [CODE_W-1:0]  code_in,
    output logic               hot_valid,
    output logic [LINES_N-1:0] hot_lines
);

    code_stage_t s1;
    pre_stage_t  s2;

    dec_in_stage u_in (
        .clk     (clk),
        .rst     (rst),
        .valid_i (code_valid),
        .code_i  (code_in),
        .stage_o (s1)
    );

    dec_predec_stage #(.W(HALF_W), .N(PRE_N)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .stage_i (s1),
        .stage_o (s2)
    );

    dec_and_array #(.N(PRE_N), .OUT(LINES_N)) u_and (
        .clk     (clk),
        .rst     (rst),
        .stage_i (s2),
        .valid_o (hot_valid),
        .lines_o (hot_lines)
    );

endmodule

// File: rtl/dec_checker.sv
module dec_checker
    import dec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               code_valid,
    input logic [CODE_W-1:0]  code_in,
    input logic               hot_valid,
    input logic [LINES_N-1:0] hot_lines
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd3) |-> (!hot_valid && hot_lines == '0)); // R1

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        hot_valid |-> ($countones(hot_lines) == 1)); // R2

    AST_LINE_INDEX: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(code_valid, 3))
            |-> (hot_lines == expect_lines($past(code_in, 3)))); // R3

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (hot_valid == $past(code_valid, 3))); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hot_valid |-> (hot_lines == '0)); // R6

endmodule

bind pipe_onehot_decoder dec_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_in    (code_in),
    .hot_valid  (hot_valid),
    .hot_lines  (hot_lines)
);

// File: tb/pipe_onehot_decoder_tb.sv
module pipe_onehot_decoder_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         code_valid = 1'b0;
    logic [7:0]   code_in = 8'd0;
    logic         hot_valid;
    logic [255:0] hot_lines;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       hv [3] = '{1'b0, 1'b0, 1'b0};
    logic [7:0] hd [3] = '{8'd0, 8'd0, 8'd0};

    always #5 clk = ~clk;

    pipe_onehot_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .code_valid (code_valid),
        .code_in    (code_in),
        .hot_valid  (hot_valid),
        .hot_lines  (hot_lines)
    );

    task automatic compare(input logic ev, input logic [7:0] ed, input string ph);
        logic [255:0] exp_lines;
        int idx;
        exp_lines = '0;
        if (ev) begin
            idx = 255 - int'(ed);
            exp_lines[idx] = 1'b1;
        end
        checks++;
        if (hot_valid !== ev) begin
            fails++;
            $display("FAIL R4 [%s] hot_valid actual=%b expected=%b", ph, hot_valid, ev);
        end
        checks++;
        if (hot_lines !== exp_lines) begin
            fails++;
            if (ev)
                $display("FAIL R3 [%s] code=%0d lines actual=%h expected=%h", ph, ed, hot_lines, exp_lines);
            else
                $display("FAIL R6 [%s] idle lines actual=%h expected=%h", ph, hot_lines, exp_lines);
        end
        if (ev) begin
            checks++;
            if ($countones(hot_lines) != 1) begin
                fails++;
                $display("FAIL R2 [%s] ones actual=%0d expected=1", ph, $countones(hot_lines));
            end
        end
    endtask

    task automatic step(input logic v, input logic [7:0] d, input string ph, input logic do_rst);
        @(negedge clk);
        compare(hv[2], hd[2], ph);
        hv[2] = hv[1]; hd[2] = hd[1];
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = d;
        if (do_rst) begin
            hv[0] = 1'b0; hv[1] = 1'b0; hv[2] = 1'b0;
        end
        rst        = do_rst;
        code_valid = v;
        code_in    = d;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step(1'b0, 8'hA5, "R1", 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 8'h3C, "R1", 1'b0);

        for (int v = 0; v < 256; v++) step(1'b1, 8'(v), "R5", 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00, "R5", 1'b0);

        for (int v = 255; v >= 200; v--) begin
            step(1'b1, 8'(v), "R6", 1'b0);
            step(1'b0, 8'(v ^ 8'h5A), "R6", 1'b0);
        end
        for (int i = 0; i < 4; i++) step(1'b0, 8'hFF, "R6", 1'b0);

        for (int v = 17; v < 22; v++) step(1'b1, 8'(v), "R7", 1'b0);
        step(1'b0, 8'h00, "R7", 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 8'(8'h81 + i), "R7", 1'b0);
        step(1'b1, 8'd0, "R7", 1'b0);
        step(1'b1, 8'd255, "R7", 1'b0);
        step(1'b1, 8'd128, "R7", 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00, "R7", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule